// File: doc/BRIEF.md
# Committed-Store Buffer with Load Forwarding

This block keeps stores that have already committed in a small ring of slots until memory has taken and acknowledged them. Stores enter at the back, one per cycle, only while a slot is free. From the oldest slot that has not yet gone out, the block offers up to a configured number of write requests per cycle to memory. Memory accepts or refuses each lane in the same cycle. A refusal parks the issue logic until memory signals that it may try again, and the same store is then offered again. A write response names the slot it completes. Slots are released strictly from the oldest end, and only once their response has arrived.

A load can probe the buffer combinationally with an address and a byte count. Every occupied store slot is compared with the load range. The answer is one of three: full cover, partial overlap or no overlap. On full cover the block returns the slot number and the load's bytes, shifted so that byte 0 is the byte at the load address. Barrier entries take a slot and keep their place in the order, but they never produce a memory request and never act as a forwarding source.

Top module: `store_fwd_buffer`

## Requirements
- R1: `canInsert` is 1 exactly while fewer than SLOTS slots are occupied; an insert pulse while it is 0 changes nothing (occupancy and `unissuedCount` stay as they were).
- R2: At most ISSUE_MAX write requests are offered per cycle. Lane k carries the k-th oldest slot not yet issued, and lane 0 is always the oldest such slot.
- R3: `unissuedCount` equals the number of occupied slots (barriers included) that the issue logic has not yet passed. It rises by one for each insert and falls by the number of lanes consumed.
- R4: `ldCover` encodes the load check as 0 = no occupied store overlaps the load range, 1 = partial overlap, 2 = full cover. A range covers the bytes from addr to addr+size-1, and sizes are 1..DBYTES.
- R5: `ldSlot` and `ldData` carry the chosen slot and its bytes only when `ldCover` is 2; otherwise both are 0.
- R6: When an offered lane is refused, that lane and all later lanes stay unissued. No request is offered until a `memRetry` pulse, and the first request after the retry is the refused store.
- R7: `drained` is 1 exactly when no slot is occupied.
- R8: A barrier entry occupies a slot and is passed by the issue logic without a memory request. It is never a forwarding source.
- R9: When several stores fully cover a load, the youngest one is chosen. If any overlapping store covers the load only partly, the result is 1 even when another store covers it fully.
- R10: Forwarded byte i (bits 8i+7..8i) is store byte (ldAddr - storeAddr + i) for i below `ldSize`; higher bytes are 0.
- R11: A slot is freed only when it is the oldest, it has been issued, and its write response (or, for a barrier, its passing) has been seen. Responses may arrive in any order, and at most one slot is freed per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert a new entry at the back |
| insBarrier | input | 1 | The new entry is a barrier |
| insAddr | input | ADDR_W | Store start address |
| insSize | input | SIZE_W | Store byte count |
| insData | input | DBYTES*8 | Store bytes, byte 0 at insAddr |
| canInsert | output | 1 | A slot is free |
| memReqValid | output | ISSUE_MAX | Write request offered per lane |
| memReqSlot | output | ISSUE_MAX*PTR_W | Slot tag per lane |
| memReqAddr | output | ISSUE_MAX*ADDR_W | Address per lane |
| memReqSize | output | ISSUE_MAX*SIZE_W | Byte count per lane |
| memReqData | output | ISSUE_MAX*DBYTES*8 | Write bytes per lane |
| memAccept | input | ISSUE_MAX | Memory takes the lane this cycle |
| memRetry | input | 1 | Memory allows another attempt after a refusal |
| memRespValid | input | 1 | A write has completed |
| memRespSlot | input | PTR_W | Slot tag of the completed write |
| ldAddr | input | ADDR_W | Load start address |
| ldSize | input | SIZE_W | Load byte count |
| ldCover | output | 2 | Coverage result |
| ldSlot | output | PTR_W | Chosen slot on full cover |
| ldData | output | DBYTES*8 | Aligned forwarded bytes |
| drained | output | 1 | No slot occupied |
| unissuedCount | output | CNT_W | Occupied slots not yet issued |

## Verification
The checker holds on every cycle several rules: the coverage code is never the unused value, forwarded data and slot are zero without full cover, a refusal silences all lanes in the following cycle, the unissued count grows by at most one per cycle, and a drained buffer always accepts inserts and has nothing pending. Youngest-wins selection, byte alignment, reissue of the refused store, in-order release under out-of-order responses, and barriers passing without a request need known contents and stimulus order. Only the bench's directed scenarios can show these.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    COVER_NONE    = 2'd0,
    COVER_PARTIAL = 2'd1,
    COVER_FULL    = 2'd2
  } cover_e;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
  } slotStrobe_t;
endpackage

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int ISSUE_MAX = 2,
  localparam int PTR_W    = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            insValid,
  input  logic [SLOTS-1:0]                barMask,
  input  logic [ISSUE_MAX-1:0]            memAccept,
  input  logic                            memRetry,
  input  logic                            memRespValid,
  input  logic [PTR_W-1:0]                memRespSlot,
  output slotStrobe_t                     stb,
  output logic [SLOTS-1:0]                occMask,
  output logic [PTR_W-1:0]                head,
  output logic [ISSUE_MAX-1:0][PTR_W-1:0] laneIdx,
  output logic [ISSUE_MAX-1:0]            memReqValid,
  output logic                            canInsert,
  output logic                            drained,
  output logic [CNT_W-1:0]                unissuedCount
);
  logic [PTR_W-1:0] tail, issPtr;
  logic [CNT_W-1:0] count, unissued, adv;
  logic [SLOTS-1:0] done;
  logic             waitRetry, rej, okChain, ins, pop;

  assign canInsert     = count < CNT_W'(SLOTS);
  assign drained       = count == '0;
  assign unissuedCount = unissued;
  assign ins           = insValid && canInsert;
  assign pop           = (count != '0) && done[head] && (unissued < count);

  always_comb begin
    stb       = '0;
    stb.wrEn  = ins;
    stb.wrIdx = IDX_W'(tail);
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++)
      occMask[s] = CNT_W'(PTR_W'(s) - head) < count;
  end

  // lanes are offered independently of accept; the accepted prefix advances
  always_comb begin
    memReqValid = '0;
    adv         = '0;
    rej         = 1'b0;
    okChain     = 1'b1;
    for (int k = 0; k < ISSUE_MAX; k++) begin
      laneIdx[k] = issPtr + PTR_W'(k);
      if (!waitRetry && (CNT_W'(k) < unissued)) begin
        if (!barMask[laneIdx[k]]) memReqValid[k] = 1'b1;
        if (okChain) begin
          if (barMask[laneIdx[k]] || memAccept[k]) adv = adv + 1'b1;
          else begin
            okChain = 1'b0;
            rej     = 1'b1;
          end
        end
      end else begin
        okChain = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head      <= '0;
      tail      <= '0;
      issPtr    <= '0;
      count     <= '0;
      unissued  <= '0;
      waitRetry <= 1'b0;
      done      <= '0;
    end else begin
      if (ins) tail <= tail + 1'b1;
      if (pop) head <= head + 1'b1;
      issPtr   <= issPtr + PTR_W'(adv);
      count    <= count + CNT_W'(ins) - CNT_W'(pop);
      unissued <= unissued + CNT_W'(ins) - adv;
      if (waitRetry) begin
        if (memRetry) waitRetry <= 1'b0;
      end else if (rej) begin
        waitRetry <= 1'b1;
      end
      for (int k = 0; k < ISSUE_MAX; k++)
        if ((CNT_W'(k) < adv) && barMask[laneIdx[k]]) done[laneIdx[k]] <= 1'b1;
      if (memRespValid) done[memRespSlot] <= 1'b1;
      if (pop) done[head] <= 1'b0;
    end
  end
endmodule

// File: rtl/sbuf_slots.sv
module sbuf_slots
  import sbuf_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int ISSUE_MAX = 2,
  parameter int ADDR_W    = 16,
  parameter int DBYTES    = 8,
  localparam int PTR_W    = $clog2(SLOTS),
  localparam int SIZE_W   = $clog2(DBYTES + 1),
  localparam int DATA_W   = DBYTES * 8
) (
  input  logic                             clk,
  input  slotStrobe_t                      stb,
  input  logic                             insBarrier,
  input  logic [ADDR_W-1:0]                insAddr,
  input  logic [SIZE_W-1:0]                insSize,
  input  logic [DATA_W-1:0]                insData,
  input  logic [SLOTS-1:0]                 occMask,
  input  logic [PTR_W-1:0]                 head,
  input  logic [ISSUE_MAX-1:0][PTR_W-1:0]  laneIdx,
  input  logic [ADDR_W-1:0]                ldAddr,
  input  logic [SIZE_W-1:0]                ldSize,
  output logic [SLOTS-1:0]                 barMask,
  output logic [ISSUE_MAX-1:0][ADDR_W-1:0] laneAddr,
  output logic [ISSUE_MAX-1:0][SIZE_W-1:0] laneSize,
  output logic [ISSUE_MAX-1:0][DATA_W-1:0] laneData,
  output logic [1:0]                       ldCover,
  output logic [PTR_W-1:0]                 ldSlot,
  output logic [DATA_W-1:0]                ldData
);
  logic [ADDR_W-1:0] sAddr [SLOTS];
  logic [SIZE_W-1:0] sSize [SLOTS];
  logic [DATA_W-1:0] sData [SLOTS];
  logic [SLOTS-1:0]  sBar;

  always_ff @(posedge clk) begin
    if (stb.wrEn) begin
      sAddr[stb.wrIdx[PTR_W-1:0]] <= insAddr;
      sSize[stb.wrIdx[PTR_W-1:0]] <= insSize;
      sData[stb.wrIdx[PTR_W-1:0]] <= insData;
      sBar[stb.wrIdx[PTR_W-1:0]]  <= insBarrier;
    end
  end

  assign barMask = sBar;

  generate
    for (genvar k = 0; k < ISSUE_MAX; k++) begin : g_lane
      assign laneAddr[k] = sAddr[laneIdx[k]];
      assign laneSize[k] = sSize[laneIdx[k]];
      assign laneData[k] = sData[laneIdx[k]];
    end
  endgenerate

  logic [ADDR_W:0]  ldEnd, stEnd;
  logic [PTR_W-1:0] idx, hit;
  logic             anyFull, anyPart, isFull, isOvl;

  // walk oldest to youngest so the last full match is the youngest
  always_comb begin
    anyFull = 1'b0;
    anyPart = 1'b0;
    hit     = '0;
    idx     = '0;
    stEnd   = '0;
    isFull  = 1'b0;
    isOvl   = 1'b0;
    ldEnd   = {1'b0, ldAddr} + (ADDR_W+1)'(ldSize);
    for (int k = 0; k < SLOTS; k++) begin
      idx    = head + PTR_W'(k);
      stEnd  = {1'b0, sAddr[idx]} + (ADDR_W+1)'(sSize[idx]);
      isFull = (sAddr[idx] <= ldAddr) && (ldEnd <= stEnd);
      isOvl  = ({1'b0, ldAddr} < stEnd) && ({1'b0, sAddr[idx]} < ldEnd);
      if (occMask[idx] && !sBar[idx]) begin
        if (isFull) begin
          anyFull = 1'b1;
          hit     = idx;
        end else if (isOvl) begin
          anyPart = 1'b1;
        end
      end
    end
  end

  logic [ADDR_W-1:0] offAddr;
  assign offAddr = ldAddr - sAddr[hit];

  always_comb begin
    ldData  = '0;
    ldSlot  = '0;
    ldCover = COVER_NONE;
    if (anyPart) begin
      ldCover = COVER_PARTIAL;
    end else if (anyFull) begin
      ldCover = COVER_FULL;
      ldSlot  = hit;
      for (int i = 0; i < DBYTES; i++)
        if ((i < int'(ldSize)) && (int'(offAddr) + i < DBYTES))
          ldData[i*8 +: 8] = sData[hit][(int'(offAddr) + i)*8 +: 8];
    end
  end
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
  import sbuf_pkg::*;
#(
  parameter int SLOTS     = 4,
  parameter int ISSUE_MAX = 2,
  parameter int ADDR_W    = 16,
  parameter int DBYTES    = 8,
  localparam int PTR_W    = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(SLOTS + 1),
  localparam int SIZE_W   = $clog2(DBYTES + 1),
  localparam int DATA_W   = DBYTES * 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        insValid,
  input  logic                        insBarrier,
  input  logic [ADDR_W-1:0]           insAddr,
  input  logic [SIZE_W-1:0]           insSize,
  input  logic [DATA_W-1:0]           insData,
  output logic                        canInsert,
  output logic [ISSUE_MAX-1:0]        memReqValid,
  output logic [ISSUE_MAX*PTR_W-1:0]  memReqSlot,
  output logic [ISSUE_MAX*ADDR_W-1:0] memReqAddr,
  output logic [ISSUE_MAX*SIZE_W-1:0] memReqSize,
  output logic [ISSUE_MAX*DATA_W-1:0] memReqData,
  input  logic [ISSUE_MAX-1:0]        memAccept,
  input  logic                        memRetry,
  input  logic                        memRespValid,
  input  logic [PTR_W-1:0]            memRespSlot,
  input  logic [ADDR_W-1:0]           ldAddr,
  input  logic [SIZE_W-1:0]           ldSize,
  output logic [1:0]                  ldCover,
  output logic [PTR_W-1:0]            ldSlot,
  output logic [DATA_W-1:0]           ldData,
  output logic                        drained,
  output logic [CNT_W-1:0]            unissuedCount
);
  slotStrobe_t                      stb;
  logic [SLOTS-1:0]                 occMask, barMask;
  logic [PTR_W-1:0]                 head;
  logic [ISSUE_MAX-1:0][PTR_W-1:0]  laneIdx;
  logic [ISSUE_MAX-1:0][ADDR_W-1:0] laneAddr;
  logic [ISSUE_MAX-1:0][SIZE_W-1:0] laneSize;
  logic [ISSUE_MAX-1:0][DATA_W-1:0] laneData;

  sbuf_ctrl #(.SLOTS(SLOTS), .ISSUE_MAX(ISSUE_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .barMask(barMask),
    .memAccept(memAccept), .memRetry(memRetry), .memRespValid(memRespValid),
    .memRespSlot(memRespSlot), .stb(stb), .occMask(occMask), .head(head),
    .laneIdx(laneIdx), .memReqValid(memReqValid), .canInsert(canInsert),
    .drained(drained), .unissuedCount(unissuedCount)
  );

  sbuf_slots #(.SLOTS(SLOTS), .ISSUE_MAX(ISSUE_MAX), .ADDR_W(ADDR_W), .DBYTES(DBYTES)) u_slots (
    .clk(clk), .stb(stb), .insBarrier(insBarrier), .insAddr(insAddr),
    .insSize(insSize), .insData(insData), .occMask(occMask), .head(head),
    .laneIdx(laneIdx), .ldAddr(ldAddr), .ldSize(ldSize), .barMask(barMask),
    .laneAddr(laneAddr), .laneSize(laneSize), .laneData(laneData),
    .ldCover(ldCover), .ldSlot(ldSlot), .ldData(ldData)
  );

  assign memReqSlot = laneIdx;
  assign memReqAddr = laneAddr;
  assign memReqSize = laneSize;
  assign memReqData = laneData;
endmodule

// File: rtl/store_fwd_buffer_chk.sv
module store_fwd_buffer_chk #(
  parameter int ISSUE_MAX = 2,
  parameter int PTR_W     = 2,
  parameter int CNT_W     = 3,
  parameter int DATA_W    = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 canInsert,
  input logic                 drained,
  input logic [CNT_W-1:0]     unissuedCount,
  input logic [ISSUE_MAX-1:0] memReqValid,
  input logic [ISSUE_MAX-1:0] memAccept,
  input logic [1:0]           ldCover,
  input logic [PTR_W-1:0]     ldSlot,
  input logic [DATA_W-1:0]    ldData
);
  p_cover_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    ldCover != 2'd3);

  p_fwd_only_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ldCover != 2'd2) |-> (ldData == '0 && ldSlot == '0));

  p_refuse_silences_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|(memReqValid & ~memAccept)) |=> (memReqValid == '0));

  p_drained_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    drained |-> (canInsert && unissuedCount == '0));

  p_unissued_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ({1'b0, unissuedCount} <= {1'b0, $past(unissuedCount)} + 1'b1));
endmodule

bind store_fwd_buffer store_fwd_buffer_chk #(
  .ISSUE_MAX(ISSUE_MAX), .PTR_W(PTR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .canInsert(canInsert), .drained(drained),
  .unissuedCount(unissuedCount), .memReqValid(memReqValid),
  .memAccept(memAccept), .ldCover(ldCover), .ldSlot(ldSlot), .ldData(ldData)
);

// File: tb/store_fwd_buffer_bench.sv
module store_fwd_buffer_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        insValid = 0, insBarrier = 0;
  logic [15:0] insAddr = 0;
  logic [3:0]  insSize = 0;
  logic [63:0] insData = 0;
  logic        canInsert;
  logic [1:0]  memReqValid;
  logic [3:0]  memReqSlot;
  logic [31:0] memReqAddr;
  logic [7:0]  memReqSize;
  logic [127:0] memReqData;
  logic [1:0]  memAccept = 0;
  logic        memRetry = 0, memRespValid = 0;
  logic [1:0]  memRespSlot = 0;
  logic [15:0] ldAddr = 0;
  logic [3:0]  ldSize = 1;
  logic [1:0]  ldCover;
  logic [1:0]  ldSlot;
  logic [63:0] ldData;
  logic        drained;
  logic [2:0]  unissuedCount;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  store_fwd_buffer u_store_fwd_buffer (.*);

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic put(input logic bar, input logic [15:0] a, input logic [3:0] s, input logic [63:0] d);
    insValid = 1; insBarrier = bar; insAddr = a; insSize = s; insData = d;
    step();
    insValid = 0; insBarrier = 0;
  endtask

  task automatic probe(input logic [15:0] a, input logic [3:0] s, input string tag,
                       input logic [1:0] cov, input logic [1:0] slot, input logic [63:0] data);
    ldAddr = a; ldSize = s; #1;
    chk({tag, " cover"}, 64'(ldCover), 64'(cov));
    chk({tag, " slot"}, 64'(ldSlot), 64'(slot));
    chk({tag, " data"}, ldData, data);
  endtask

  task automatic t_reset();
    chk("R1 reset canInsert", 64'(canInsert), 1);
    chk("R7 reset drained", 64'(drained), 1);
    chk("R3 reset unissued", 64'(unissuedCount), 0);
    chk("R2 reset no request", 64'(memReqValid), 0);
  endtask

  task automatic t_fill();
    memAccept = 2'b00;
    put(0, 16'h0100, 8, 64'h1716151413121110);
    put(0, 16'h0104, 4, 64'h23222120);
    put(0, 16'h0200, 2, 64'h3130);
    put(0, 16'h0300, 4, 64'h43424140);
    chk("R1 full canInsert", 64'(canInsert), 0);
    chk("R7 not drained", 64'(drained), 0);
    put(0, 16'h0500, 4, 64'h55);
    chk("R1 ignored insert unissued", 64'(unissuedCount), 4);
    chk("R3 unissued after fill", 64'(unissuedCount), 4);
    chk("R6 waiting after refusal", 64'(memReqValid), 0);
  endtask

  task automatic t_forward();
    probe(16'h0104, 4, "R9 youngest full", 2, 1, 64'h23222120);
    probe(16'h0100, 2, "R10 low bytes", 2, 0, 64'h1110);
    probe(16'h0201, 1, "R10 offset byte", 2, 2, 64'h31);
    probe(16'h0106, 4, "R9 partial wins", 1, 0, 0);
    probe(16'h01FF, 2, "R4 partial", 1, 0, 0);
    probe(16'h0400, 4, "R5 none", 0, 0, 0);
  endtask

  task automatic t_issue();
    memRetry = 1; step(); memRetry = 0;
    chk("R2 two lanes", 64'(memReqValid), 2'b11);
    chk("R2 lane0 oldest", 64'(memReqSlot[1:0]), 0);
    chk("R2 lane1 next", 64'(memReqSlot[3:2]), 1);
    chk("R2 lane0 addr", 64'(memReqAddr[15:0]), 16'h0100);
    memAccept = 2'b01; step();
    chk("R3 one consumed", 64'(unissuedCount), 3);
    chk("R6 silent after refusal", 64'(memReqValid), 0);
    memAccept = 2'b00;
    memRetry = 1; step(); memRetry = 0;
    chk("R6 refused store reissued", 64'(memReqSlot[1:0]), 1);
    chk("R6 reissued data", memReqData[63:0], 64'h23222120);
    memAccept = 2'b11; step();
    chk("R3 after pair", 64'(unissuedCount), 1);
    chk("R2 single lane left", 64'(memReqValid), 2'b01);
    chk("R2 last slot", 64'(memReqSlot[1:0]), 3);
    step();
    memAccept = 2'b00;
    chk("R3 all issued", 64'(unissuedCount), 0);
    chk("R2 idle", 64'(memReqValid), 0);
  endtask

  task automatic t_release();
    memRespValid = 1; memRespSlot = 2; step(); memRespValid = 0;
    step();
    chk("R11 young response frees nothing", 64'(canInsert), 0);
    probe(16'h0100, 2, "R11 oldest still forwards", 2, 0, 64'h1110);
    memRespValid = 1; memRespSlot = 0; step(); memRespValid = 0;
    step();
    chk("R11 oldest freed", 64'(canInsert), 1);
    memRespValid = 1; memRespSlot = 3; step();
    memRespSlot = 1; step(); memRespValid = 0;
    step(); step(); step();
    chk("R7 drained after responses", 64'(drained), 1);
  endtask

  task automatic t_barrier();
    memAccept = 2'b00;
    put(1, 16'h0100, 8, 64'h0);
    chk("R8 barrier unissued", 64'(unissuedCount), 1);
    chk("R8 barrier no request", 64'(memReqValid), 0);
    probe(16'h0100, 4, "R8 barrier not a source", 0, 0, 0);
    step();
    chk("R8 barrier passed", 64'(unissuedCount), 0);
    step();
    chk("R8 barrier slot freed", 64'(drained), 1);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    t_reset();
    t_fill();
    t_forward();
    t_issue();
    t_release();
    t_barrier();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule